// File: doc/BRIEF.md
# Folded-Word Phase Accumulator Clock Source

This block turns a fixed reference clock into a set of slower square waves. Each channel has a 16-bit frequency word. The word is written one byte at a time through a small write port. The channel adds a phase increment derived from that word to a 16-bit accumulator on every reference cycle. The accumulator's top bit is the output wave. A one-cycle tick marks each cycle in which the wave goes high. A constant-frequency PWM stage further down the chip uses the tick stream as its timebase.

Words at or above half scale are folded to their 16-bit two's complement before use. The increment therefore never exceeds 0x8000, and the output frequency is increment / 65536 of the reference frequency. A power-of-two increment gives an exact 50% duty wave. That is the mode used when the output clocks the PWM stage, with usable words from 1 to 32768.

The write port is a plain register strobe with no back-pressure, because every write is accepted in the cycle it is presented. The run inputs and the outputs are plain level and pulse pins.

Top module: `vfg_gen`

## Requirements
- R1: A write with `wr_en` high targets the channel given by `wr_addr[ADDR_W-1:1]`. `wr_addr[0]` selects the half: 1 is the upper byte (bits 15:8) and 0 is the lower byte (bits 7:0).
- R2: A channel's active word changes only when both halves have been written since its last change, in either order. The change happens at the clock edge of the second write. The new increment is first added at the following edge. A lone half write leaves the output pattern unchanged.
- R3: Writing the same half again before its partner replaces the staged byte and does not change the active word.
- R4: The increment is the word itself when the word is below 0x8000, and 65536 minus the word otherwise. Words w and 65536-w give identical outputs, 0x8000 stays 0x8000, and 0 gives an increment of 0.
- R5: While a channel's run input is high, its accumulator advances by the increment modulo 2^16 at every edge, and `wave` is the accumulator's bit 15.
- R6: `tick` is high for exactly one cycle, the first cycle in which `wave` is high after being low.
- R7: While run is low, the accumulator clears at the next edge, and `wave` and `tick` are low. After run returns high, counting restarts from zero.
- R8: After reset all words, staged bytes and accumulators are zero, so no ticks appear even with run high.
- R9: For a word 2^k (6 ≤ k ≤ 15), the wave is high for exactly 65536/2^k cycles in every 2·65536/2^k cycles from a restart, with two ticks in that window.
- R10: Writes and run changes on one channel leave every other channel's output unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | ADDR_W | Channel index above bit 0, half select at bit 0 |
| wr_data | input | BYTE_W | Byte to write |
| chan_run | input | NUM_CH | Per-channel run enable |
| wave | output | NUM_CH | Accumulator top bit per channel |
| tick | output | NUM_CH | One-cycle rising-edge pulse per channel |

## Verification
The bench tries a sweep of about fifty words that cover both sides of the fold point, plus the values 0x7FFF, 0x8000, 0x8001 and 0xFFFF. Across this sweep, a missing or wrong fold is the only thing that makes the outputs differ from the arithmetic model. Mirror pairs w and 65536-w are recorded and compared bit for bit, which checks the fold without the model. Power-of-two words from 2^6 to 2^15 are counted for high cycles and ticks, which separates exact 50% duty from an off-by-one period. Byte sequences with a lone half, a repeated half and a reversed order separate correct commit staging from a design that applies half-written words.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/vfg_cword_reg.sv
module vfg_cword_reg
  import vfg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  half_e             wr_half,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic [WORD_W-1:0] word
);
  localparam int HI_W = WORD_W - BYTE_W;

  logic [BYTE_W-1:0] stg_lo;
  logic [HI_W-1:0]   stg_hi;
  logic              have_lo, have_hi;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_lo  <= '0;
      stg_hi  <= '0;
      have_lo <= 1'b0;
      have_hi <= 1'b0;
      word_q  <= '0;
    end else if (wr_hit) begin
      if (wr_half == HALF_HI) begin
        if (have_lo) begin
          word_q  <= {wr_byte[HI_W-1:0], stg_lo};
          have_lo <= 1'b0;
          have_hi <= 1'b0;
        end else begin
          stg_hi  <= wr_byte[HI_W-1:0];
          have_hi <= 1'b1;
        end
      end else begin
        if (have_hi) begin
          word_q  <= {stg_hi, wr_byte};
          have_lo <= 1'b0;
          have_hi <= 1'b0;
        end else begin
          stg_lo  <= wr_byte;
          have_lo <= 1'b1;
        end
      end
    end
  end

  assign word = word_q;

  // R2: the word only moves on the edge of a write, and staging is empty after it
  assert_commit_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> $past(wr_hit));
  assert_staging_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_q) |-> (!have_lo && !have_hi));
  // R3: an upper byte with no lower byte staged never touches the word
  assert_lone_half_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && wr_half == HALF_HI && !have_lo) |=> $stable(word_q));
endmodule

// File: rtl/vfg_fold.sv
module vfg_fold #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] cw,
  output logic [WORD_W-1:0] inc
);
  localparam logic [WORD_W-1:0] HALF = WORD_W'(1) << (WORD_W - 1);

  always_comb begin
    if (cw[WORD_W-1]) inc = ~cw + 1'b1;
    else              inc = cw;
    // R4: a folded increment never exceeds half scale
    assert_inc_bound_R4: assert (inc <= HALF);
  end
endmodule

// File: rtl/vfg_accum.sv
module vfg_accum #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [ACC_W-1:0] inc,
  output logic             wave,
  output logic             tick
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic             tick_q;

  assign sum = acc_q + inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else if (!run) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= sum;
      tick_q <= sum[ACC_W-1] & ~acc_q[ACC_W-1];
    end
  end

  assign wave = acc_q[ACC_W-1];
  assign tick = tick_q;

  // R7: a stopped channel is parked at zero with no pulse
  assert_stop_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_q == '0 && !tick_q));
  // R6: a tick only marks the first high cycle of the wave
  assert_tick_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (acc_q[ACC_W-1] && !$past(acc_q[ACC_W-1])));
endmodule

// File: rtl/vfg_gen.sv
module vfg_gen
  import vfg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int WORD_W = 16,
  parameter int BYTE_W = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [NUM_CH-1:0] chan_run,
  output logic [NUM_CH-1:0] wave,
  output logic [NUM_CH-1:0] tick
);
  half_e wr_half;
  assign wr_half = half_e'(wr_addr[0]);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic              hit;
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] inc;

    assign hit = wr_en && (wr_addr[ADDR_W-1:1] == CH_W'(ch));

    vfg_cword_reg #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_word (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (hit),
      .wr_half (wr_half),
      .wr_byte (wr_data),
      .word    (word)
    );

    vfg_fold #(.WORD_W(WORD_W)) u_fold (
      .cw  (word),
      .inc (inc)
    );

    vfg_accum #(.ACC_W(WORD_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (chan_run[ch]),
      .inc   (inc),
      .wave  (wave[ch]),
      .tick  (tick[ch])
    );
  end
endmodule

// File: tb/tb_vfg_gen.sv
`timescale 1ns/1ps
module tb_vfg_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] chan_run;
  logic [1:0] wave, tick;

  vfg_gen dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan_run(chan_run), .wave(wave), .tick(tick)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int m_word[2], m_lo[2], m_hi[2], m_acc[2];
  bit m_hlo[2], m_hhi[2], m_tick[2];
  bit p_en; int p_addr, p_data;
  int err_w, err_t, act_w, exp_w, act_t, exp_t;

  function automatic int fold_m(int cw);
    return (cw >= 32768) ? 65536 - cw : cw;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      int nxt;
      nxt = chan_run[c] ? ((m_acc[c] + fold_m(m_word[c])) & 16'hFFFF) : 0;
      m_tick[c] = chan_run[c] && nxt[15] && !m_acc[c][15];
      m_acc[c] = nxt;
    end
    if (p_en) begin
      int c;
      c = p_addr >> 1;
      if (p_addr % 2 == 1) begin
        if (m_hlo[c]) begin m_word[c] = (p_data << 8) | m_lo[c]; m_hlo[c] = 0; m_hhi[c] = 0; end
        else begin m_hi[c] = p_data; m_hhi[c] = 1; end
      end else begin
        if (m_hhi[c]) begin m_word[c] = (m_hi[c] << 8) | p_data; m_hlo[c] = 0; m_hhi[c] = 0; end
        else begin m_lo[c] = p_data; m_hlo[c] = 1; end
      end
      p_en = 0;
    end
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      if (wave[c] != m_acc[c][15]) begin
        if (err_w == 0) begin act_w = int'(wave[c]); exp_w = int'(m_acc[c][15]); end
        err_w++;
      end
      if (tick[c] != m_tick[c]) begin
        if (err_t == 0) begin act_t = int'(tick[c]); exp_t = int'(m_tick[c]); end
        err_t++;
      end
    end
  endtask

  task automatic wr(bit ch, bit hi, int data);
    wr_en = 1'b1; wr_addr = {ch, hi}; wr_data = 8'(data);
    p_en = 1; p_addr = {ch, hi}; p_data = data & 8'hFF;
    step();
    wr_en = 1'b0;
  endtask

  task automatic load(bit ch, int cw);
    wr(ch, 1'b1, cw >> 8);
    wr(ch, 1'b0, cw & 8'hFF);
  endtask

  task automatic open_win();
    err_w = 0; err_t = 0;
  endtask

  task automatic close_win(string rw, string rt, string what);
    chk(err_w == 0, rw, {what, " wave"}, act_w, exp_w);
    chk(err_t == 0, rt, {what, " tick"}, act_t, exp_t);
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(150000 * 5);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; chan_run = '0; p_en = 0;
    for (int c = 0; c < 2; c++) begin
      m_word[c] = 0; m_lo[c] = 0; m_hi[c] = 0; m_acc[c] = 0;
      m_hlo[c] = 0; m_hhi[c] = 0; m_tick[c] = 0;
    end
    repeat (3) @(negedge clk);
    chk(wave == 2'b00 && tick == 2'b00, "R8", "outputs in reset", int'({wave, tick}), 0);
    rst_n = 1'b1;

    // R8: zero word after reset gives no ticks even when running
    chan_run = 2'b11; open_win(); run_n(40);
    close_win("R8", "R8", "zero word after reset");

    // R1 R5 R6: both channels loaded and running, upper byte first on ch0
    open_win();
    wr(1'b0, 1'b1, 8'h01); wr(1'b0, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h37); wr(1'b1, 1'b1, 8'h02);
    run_n(700);
    close_win("R5", "R6", "R1 address map and accumulation");

    // R2: lone upper byte is held; R3: rewritten upper byte replaces the staged one
    open_win();
    wr(1'b0, 1'b1, 8'h10); run_n(300);
    close_win("R2", "R2", "lone half held");
    open_win();
    wr(1'b0, 1'b1, 8'h04); run_n(50); wr(1'b0, 1'b0, 8'h00); run_n(300);
    close_win("R3", "R3", "rewrite of staged half");

    // R2: reverse order, lower byte first
    open_win();
    wr(1'b0, 1'b0, 8'h80); run_n(20); wr(1'b0, 1'b1, 8'h00); run_n(1100);
    close_win("R2", "R2", "lower byte first");

    // R10: ch1 rewritten and stopped while ch0 keeps running
    open_win();
    load(1'b1, 16'h0C00); run_n(100); chan_run[1] = 1'b0; run_n(50);
    wr(1'b1, 1'b1, 8'h55); run_n(100); chan_run[1] = 1'b1; run_n(200);
    close_win("R10", "R10", "channel isolation");

    // R7: stop clears at the next edge, restart counts from zero
    chan_run[0] = 1'b0; step();
    chk(wave[0] == 1'b0 && tick[0] == 1'b0, "R7", "stopped output", int'({wave[0], tick[0]}), 0);
    chan_run[0] = 1'b1; open_win(); run_n(400);
    close_win("R7", "R7", "restart from zero");

    // R4: sweep across the fold point plus edge words
    for (int i = 0; i < 52; i++) begin
      int cw;
      if (i < 48) cw = (i * 16'h0557 + 16'h0013) & 16'hFFFF;
      else if (i == 48) cw = 16'h7FFF;
      else if (i == 49) cw = 16'h8000;
      else if (i == 50) cw = 16'h8001;
      else cw = 16'hFFFF;
      chan_run[0] = 1'b0; step();
      load(1'b0, cw);
      chan_run[0] = 1'b1; open_win(); run_n(64);
      close_win("R4", "R4", $sformatf("word 0x%04h", cw));
    end

    // R4: mirror words give identical wave patterns, checked without the model
    for (int j = 0; j < 3; j++) begin
      logic [63:0] pa, pb;
      int cw;
      cw = (j == 0) ? 16'h1234 : (j == 1) ? 16'h0001 : 16'h7ABC;
      for (int s = 0; s < 2; s++) begin
        chan_run[0] = 1'b0; step();
        load(1'b0, (s == 0) ? cw : 65536 - cw);
        chan_run[0] = 1'b1;
        for (int k = 0; k < 64; k++) begin
          step();
          if (s == 0) pa[k] = wave[0]; else pb[k] = wave[0];
        end
      end
      chk(pa == pb, "R4", $sformatf("mirror pair 0x%04h", cw), int'(pa[31:0]), int'(pb[31:0]));
    end

    // R9: power-of-two words give exact half duty and two ticks per two periods
    for (int k = 6; k <= 15; k++) begin
      int per, hi_cnt, tk_cnt;
      per = 65536 >> k;
      chan_run[0] = 1'b0; step();
      load(1'b0, 1 << k);
      chan_run[0] = 1'b1; hi_cnt = 0; tk_cnt = 0;
      for (int n = 0; n < 2 * per; n++) begin
        step();
        hi_cnt += int'(wave[0]);
        tk_cnt += int'(tick[0]);
      end
      chk(hi_cnt == per, "R9", $sformatf("high cycles for 2^%0d", k), hi_cnt, per);
      chk(tk_cnt == 2, "R9", $sformatf("ticks for 2^%0d", k), tk_cnt, 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule